// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold Gate

This block decides when the packet at the head of an asynchronous transmit FIFO may begin leaving on the serial link. A host-side writer pushes 32-bit words into the FIFO and marks the last word of each packet. The block counts the bytes checked in for the packet being written and compares them with a start level chosen by a 2-bit code. The link side sees a release indication and answers with a start strobe when it begins a packet, and a done strobe when that attempt ends.

A packet is released early (cut-through) once its byte count reaches the start level, or once it is complete, whichever comes first. If the FIFO runs dry while a cut-through packet is still being sent and its last word has not been written, the block reports an underrun, flags a packet error and forces store-and-forward until the retry of that packet has finished. Store-and-forward is also forced for code 00 and whenever the retry limit is zero. The FIFO storage, the link arbitration and the register decode are outside the block; the FIFO empty state, the retry limit and the code come in as inputs.

Top module: `tx_start_gate`

## Requirements
- R1: After synchronous reset, `release_o`, `underrun_o` and `pkt_err_o` are low and the start-level code is 01, so an incomplete packet of 1740 bytes is released and one of 1736 bytes is not.
- R2: Each pushed word adds 4 bytes; with code 11, 10 or 01 (start levels 512, 1024, 1740 bytes), an incomplete packet is released when its byte count is at or above the level and held below it. The code is taken from `cfg_code_i` when `cfg_load_i` is high.
- R3: A packet whose last word has been pushed with `push_eop_i` high is released regardless of its size.
- R4: With code 00, an incomplete packet is never released, even beyond 2048 bytes, and `sf_mode_o` is high.
- R5: With `retry_limit_i` equal to zero, an incomplete packet is never released whatever the code, and `sf_mode_o` is high.
- R6: If a released packet is still being written and the FIFO is empty in a cycle with no push, `underrun_o` is high for exactly one cycle in the next cycle and `pkt_err_o` rises with it and stays high until `err_ack_i`.
- R7: After an underrun, the errored packet is not released again until its last word has been pushed, even above the start level, and `sf_mode_o` stays high.
- R8: When the link signals `done_i` for the retried packet, the store-and-forward override clears and the next packet is released again at the coded start level.
- R9: Releases are limited to `PIPE_DEPTH` packets in flight (started and not done); with `no_pipe_i` high the limit is one.
- R10: A packet released while still being written is released only once: after its start strobe, further pushes to it do not raise `release_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load_i | input | 1 | Load `cfg_code_i` into the start-level code |
| cfg_code_i | input | 2 | Start-level code: 00 store-and-forward, 01 1740 B, 10 1024 B, 11 512 B |
| retry_limit_i | input | RETRY_W | Asynchronous retry limit; zero forces store-and-forward |
| no_pipe_i | input | 1 | Allow only one packet in flight |
| push_i | input | 1 | Writer pushes one word into the FIFO |
| push_eop_i | input | 1 | Pushed word is the last of its packet |
| fifo_empty_i | input | 1 | FIFO holds no words |
| start_i | input | 1 | Link starts the head packet (taken when `release_o` is high) |
| done_i | input | 1 | Link finished the current attempt |
| err_ack_i | input | 1 | Clears the packet-error flag |
| release_o | output | 1 | Head packet may start |
| underrun_o | output | 1 | One-cycle underrun strobe |
| pkt_err_o | output | 1 | Packet error, held until acknowledged |
| sf_mode_o | output | 1 | Store-and-forward currently in force |

## Verification
The bench builds the block with its defaults: 4-byte words, a 4096-byte count ceiling, two packets in flight and the combinational compare. With those values every start level lies on a word boundary, so the word just below and the word at each level can both be driven, and three short packets are enough to reach and then hit the in-flight limit in both pipelined and single-packet modes. The underrun, retry and override-clear sequence is driven end to end on one packet.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;

   typedef enum logic [1:0] {
      THR_STORE = 2'b00,
      THR_HIGH  = 2'b01,
      THR_MID   = 2'b10,
      THR_LOW   = 2'b11
   } thr_code_e;

   localparam thr_code_e THR_RESET = THR_HIGH;

   // Start level in bytes for each code.
   function automatic int unsigned thr_bytes(input thr_code_e code);
      case (code)
         THR_STORE: thr_bytes = 2048;
         THR_HIGH:  thr_bytes = 1740;
         THR_MID:   thr_bytes = 1024;
         default:   thr_bytes = 512;
      endcase
   endfunction

endpackage

// File: rtl/tx_gate_wrcount.sv
module tx_gate_wrcount #(
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned CNT_W      = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push_i,
   input  logic             eop_i,
   output logic [CNT_W-1:0] byte_cnt_o,
   output logic             pkt_done_o
);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] STEP     = CNT_W'(WORD_BYTES);
   localparam logic [CNT_W-1:0] SAT_EDGE = CNT_MAX - STEP;

   logic [CNT_W-1:0] cnt_q;

   assign pkt_done_o = push_i & eop_i;
   assign byte_cnt_o = cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (push_i && eop_i)
         cnt_q <= '0;
      else if (push_i)
         cnt_q <= (cnt_q > SAT_EDGE) ? CNT_MAX : cnt_q + STEP;
   end

   // R2: one word pushed mid-packet grows the count by exactly one word
   assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
      (push_i && !eop_i && cnt_q <= SAT_EDGE) |=> byte_cnt_o == $past(byte_cnt_o) + STEP);

   // R3: the last word of a packet restarts counting for the next one
   assert_count_restart_R3: assert property (@(posedge clk) disable iff (rst)
      (push_i && eop_i) |=> byte_cnt_o == '0);

endmodule

// File: rtl/tx_gate_cmp.sv
module tx_gate_cmp #(
   parameter int unsigned CNT_W   = 13,
   parameter bit          REG_CMP = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  tx_gate_pkg::thr_code_e code_i,
   input  logic [CNT_W-1:0]      byte_cnt_i,
   output logic                  cut_ok_o
);
   import tx_gate_pkg::*;

   logic [CNT_W-1:0] level;
   logic             reached;

   always_comb begin
      level   = CNT_W'(thr_bytes(code_i));
      reached = (code_i != THR_STORE) && (byte_cnt_i >= level);
   end

   generate
      if (REG_CMP) begin : g_reg
         logic reached_q;
         always_ff @(posedge clk) begin
            if (rst) reached_q <= 1'b0;
            else     reached_q <= reached;
         end
         assign cut_ok_o = reached_q;
      end else begin : g_comb
         assign cut_ok_o = reached;
      end
   endgenerate

   // R4: code 00 never permits cut-through
   assert_store_no_cut_R4: assert property (@(posedge clk) disable iff (rst)
      (!REG_CMP && code_i == THR_STORE) |-> !cut_ok_o);

endmodule

// File: rtl/tx_gate_track.sv
module tx_gate_track #(
   parameter int unsigned PIPE_DEPTH = 2,
   parameter int unsigned QUEUE_W    = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic pkt_done_i,
   input  logic cut_ok_i,
   input  logic sf_cfg_i,
   input  logic no_pipe_i,
   input  logic push_i,
   input  logic fifo_empty_i,
   input  logic start_i,
   input  logic done_i,
   input  logic err_ack_i,
   output logic release_o,
   output logic underrun_o,
   output logic pkt_err_o,
   output logic sf_force_o
);
   localparam int unsigned IF_W = $clog2(PIPE_DEPTH + 1);
   localparam logic [IF_W-1:0]    IF_MAX = IF_W'(PIPE_DEPTH);
   localparam logic [QUEUE_W-1:0] Q_MAX  = '1;

   logic [QUEUE_W-1:0] ready_q;
   logic [IF_W-1:0]    inflight_q;
   logic               wr_started_q;
   logic               sf_force_q;
   logic               retry_live_q;
   logic               underrun_q;
   logic               err_q;

   logic [IF_W-1:0] limit;
   logic            room, head_ready, cut_allowed;
   logic            accept, acc_head, acc_open;
   logic            underrun_now, queue_new;

   always_comb begin
      limit        = no_pipe_i ? IF_W'(1) : IF_MAX;
      room         = inflight_q < limit;
      head_ready   = ready_q != '0;
      cut_allowed  = cut_ok_i && !sf_cfg_i && !sf_force_q && !wr_started_q;
      release_o    = room && (head_ready || cut_allowed);
      accept       = start_i && release_o;
      acc_head     = accept && head_ready;
      acc_open     = accept && !head_ready;
      underrun_now = wr_started_q && fifo_empty_i && !push_i;
      queue_new    = pkt_done_i && !wr_started_q && !acc_open;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q      <= '0;
         inflight_q   <= '0;
         wr_started_q <= 1'b0;
         sf_force_q   <= 1'b0;
         retry_live_q <= 1'b0;
         underrun_q   <= 1'b0;
         err_q        <= 1'b0;
      end else begin
         // complete packets waiting for the link
         case ({queue_new, acc_head})
            2'b10:   ready_q <= ready_q + 1'b1;
            2'b01:   ready_q <= ready_q - 1'b1;
            default: ready_q <= ready_q;
         endcase

         // packets started on the link and not yet finished
         if (accept && !(done_i && inflight_q != '0) && !underrun_now)
            inflight_q <= inflight_q + 1'b1;
         else if (!accept && ((done_i && inflight_q != '0) || underrun_now))
            inflight_q <= inflight_q - 1'b1;

         // open packet already on its way (cut-through)
         if (pkt_done_i || underrun_now) wr_started_q <= 1'b0;
         else if (acc_open)              wr_started_q <= 1'b1;

         // store-and-forward override for the retry
         if (underrun_now) begin
            sf_force_q   <= 1'b1;
            retry_live_q <= 1'b0;
         end else if (done_i && retry_live_q) begin
            sf_force_q   <= 1'b0;
            retry_live_q <= 1'b0;
         end else if (accept && sf_force_q) begin
            retry_live_q <= 1'b1;
         end

         underrun_q <= underrun_now;
         if (underrun_now)   err_q <= 1'b1;
         else if (err_ack_i) err_q <= 1'b0;
      end
   end

   assign underrun_o = underrun_q;
   assign pkt_err_o  = err_q;
   assign sf_force_o = sf_force_q;

   // R9: no release once the in-flight limit is reached
   assert_pipe_limit_R9: assert property (@(posedge clk) disable iff (rst)
      (no_pipe_i && inflight_q != '0) |-> !release_o);

   assert_inflight_bound_R9: assert property (@(posedge clk) disable iff (rst)
      inflight_q <= IF_MAX);

   // R10: an open packet is started at most once
   assert_single_release_R10: assert property (@(posedge clk) disable iff (rst)
      (acc_open && !pkt_done_i) |=> !release_o || head_ready);

   // R6: strobe lasts one cycle and the error flag accompanies it
   assert_underrun_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      underrun_o |=> !underrun_o);

   assert_underrun_err_R6: assert property (@(posedge clk) disable iff (rst)
      underrun_o |-> pkt_err_o);

   assert_err_held_R6: assert property (@(posedge clk) disable iff (rst)
      (pkt_err_o && !err_ack_i) |=> pkt_err_o);

   // R7: after an underrun only complete packets go out
   assert_retry_complete_R7: assert property (@(posedge clk) disable iff (rst)
      (sf_force_q && !head_ready) |-> !release_o);

   // R3: the completion queue never wraps
   assert_queue_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      queue_new |-> ready_q != Q_MAX);

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
   parameter int unsigned WORD_BYTES    = 4,
   parameter int unsigned MAX_PKT_BYTES = 4096,
   parameter int unsigned PIPE_DEPTH    = 2,
   parameter int unsigned QUEUE_W       = 4,
   parameter int unsigned RETRY_W       = 4,
   parameter bit          REG_CMP       = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_load_i,
   input  logic [1:0]         cfg_code_i,
   input  logic [RETRY_W-1:0] retry_limit_i,
   input  logic               no_pipe_i,
   input  logic               push_i,
   input  logic               push_eop_i,
   input  logic               fifo_empty_i,
   input  logic               start_i,
   input  logic               done_i,
   input  logic               err_ack_i,
   output logic               release_o,
   output logic               underrun_o,
   output logic               pkt_err_o,
   output logic               sf_mode_o
);
   import tx_gate_pkg::*;

   localparam int unsigned CNT_W = $clog2(MAX_PKT_BYTES + 1);

   generate
      if (MAX_PKT_BYTES < 2048) begin : g_bad_max
         $error("MAX_PKT_BYTES must cover the 2048-byte level");
      end
      if (WORD_BYTES == 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (PIPE_DEPTH < 1) begin : g_bad_pipe
         $error("PIPE_DEPTH must be at least one");
      end
      if (QUEUE_W < 1 || RETRY_W < 1) begin : g_bad_width
         $error("QUEUE_W and RETRY_W must be positive");
      end
   endgenerate

   thr_code_e        code_q;
   logic [CNT_W-1:0] byte_cnt;
   logic             pkt_done, cut_ok, sf_cfg, sf_force;

   always_ff @(posedge clk) begin
      if (rst)             code_q <= THR_RESET;
      else if (cfg_load_i) code_q <= thr_code_e'(cfg_code_i);
   end

   assign sf_cfg    = (code_q == THR_STORE) || (retry_limit_i == '0);
   assign sf_mode_o = sf_cfg || sf_force;

   tx_gate_wrcount #(
      .WORD_BYTES (WORD_BYTES),
      .CNT_W      (CNT_W)
   ) u_wrcount (
      .clk        (clk),
      .rst        (rst),
      .push_i     (push_i),
      .eop_i      (push_eop_i),
      .byte_cnt_o (byte_cnt),
      .pkt_done_o (pkt_done)
   );

   tx_gate_cmp #(
      .CNT_W      (CNT_W),
      .REG_CMP    (REG_CMP)
   ) u_cmp (
      .clk        (clk),
      .rst        (rst),
      .code_i     (code_q),
      .byte_cnt_i (byte_cnt),
      .cut_ok_o   (cut_ok)
   );

   tx_gate_track #(
      .PIPE_DEPTH (PIPE_DEPTH),
      .QUEUE_W    (QUEUE_W)
   ) u_track (
      .clk          (clk),
      .rst          (rst),
      .pkt_done_i   (pkt_done),
      .cut_ok_i     (cut_ok),
      .sf_cfg_i     (sf_cfg),
      .no_pipe_i    (no_pipe_i),
      .push_i       (push_i),
      .fifo_empty_i (fifo_empty_i),
      .start_i      (start_i),
      .done_i       (done_i),
      .err_ack_i    (err_ack_i),
      .release_o    (release_o),
      .underrun_o   (underrun_o),
      .pkt_err_o    (pkt_err_o),
      .sf_force_o   (sf_force)
   );

   // R5: a zero retry limit keeps store-and-forward in force
   assert_retry_zero_sf_R5: assert property (@(posedge clk) disable iff (rst)
      (retry_limit_i == '0) |-> sf_mode_o);

   // R1: the code register leaves reset at 01
   assert_reset_code_R1: assert property (@(posedge clk)
      $past(rst) && !cfg_load_i |-> code_q == THR_HIGH);

endmodule

// File: tb/tx_start_gate_tb_top.sv
module tx_start_gate_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_load_i = 1'b0;
   logic [1:0] cfg_code_i = 2'b01;
   logic [3:0] retry_limit_i = 4'd3;
   logic       no_pipe_i = 1'b0;
   logic       push_i = 1'b0;
   logic       push_eop_i = 1'b0;
   logic       fifo_empty_i = 1'b0;
   logic       start_i = 1'b0;
   logic       done_i = 1'b0;
   logic       err_ack_i = 1'b0;
   logic       release_o, underrun_o, pkt_err_o, sf_mode_o;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  closed = 1'b0;

   always #2.5 clk = ~clk;

   tx_start_gate dut_i (
      .clk           (clk),
      .rst           (rst),
      .cfg_load_i    (cfg_load_i),
      .cfg_code_i    (cfg_code_i),
      .retry_limit_i (retry_limit_i),
      .no_pipe_i     (no_pipe_i),
      .push_i        (push_i),
      .push_eop_i    (push_eop_i),
      .fifo_empty_i  (fifo_empty_i),
      .start_i       (start_i),
      .done_i        (done_i),
      .err_ack_i     (err_ack_i),
      .release_o     (release_o),
      .underrun_o    (underrun_o),
      .pkt_err_o     (pkt_err_o),
      .sf_mode_o     (sf_mode_o)
   );

   // code, retry nonzero, words, last word marked, expected release, requirement
   typedef struct packed {
      logic [1:0]  code;
      logic        retry_nz;
      logic [10:0] words;
      logic        eop;
      logic        exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{2'b01, 1'b1, 11'd435, 1'b0, 1'b1, 4'd2},
      '{2'b01, 1'b1, 11'd434, 1'b0, 1'b0, 4'd2},
      '{2'b10, 1'b1, 11'd256, 1'b0, 1'b1, 4'd2},
      '{2'b10, 1'b1, 11'd255, 1'b0, 1'b0, 4'd2},
      '{2'b11, 1'b1, 11'd128, 1'b0, 1'b1, 4'd2},
      '{2'b11, 1'b1, 11'd127, 1'b0, 1'b0, 4'd2},
      '{2'b00, 1'b1, 11'd600, 1'b0, 1'b0, 4'd4},
      '{2'b00, 1'b1, 11'd3,   1'b1, 1'b1, 4'd4},
      '{2'b11, 1'b0, 11'd200, 1'b0, 1'b0, 4'd5},
      '{2'b11, 1'b0, 11'd200, 1'b1, 1'b1, 4'd5},
      '{2'b01, 1'b1, 11'd10,  1'b1, 1'b1, 4'd3}
   };

   function automatic string req_tag(input int r);
      case (r)
         2:       return "R2";
         3:       return "R3";
         4:       return "R4";
         5:       return "R5";
         default: return "R?";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      push_i = 1'b0; push_eop_i = 1'b0; start_i = 1'b0; done_i = 1'b0;
      err_ack_i = 1'b0; fifo_empty_i = 1'b0; cfg_load_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic load_code(input logic [1:0] c);
      @(negedge clk);
      cfg_code_i = c; cfg_load_i = 1'b1;
      @(negedge clk);
      cfg_load_i = 1'b0;
   endtask

   task automatic push_words(input int n, input bit mark_last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         push_i = 1'b1;
         push_eop_i = mark_last && (i == n - 1);
      end
      @(negedge clk);
      push_i = 1'b0; push_eop_i = 1'b0;
   endtask

   task automatic strobe_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic strobe_done();
      @(negedge clk); done_i = 1'b1;
      @(negedge clk); done_i = 1'b0;
   endtask

   task automatic close_run();
      if (!closed) begin
         closed = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      close_run();
   end

   initial begin
      // R1: reset state
      do_reset();
      @(negedge clk);
      check("R1", "release after reset", release_o, 0);
      check("R1", "underrun after reset", underrun_o, 0);
      check("R1", "pkt_err after reset", pkt_err_o, 0);
      check("R1", "sf_mode after reset", sf_mode_o, 0);
      push_words(435, 1'b0);
      check("R1", "default code releases 1740 B", release_o, 1);
      do_reset();
      push_words(434, 1'b0);
      check("R1", "default code holds 1736 B", release_o, 0);

      // table of start-level vectors
      for (int v = 0; v < NV; v++) begin
         do_reset();
         retry_limit_i = VECS[v].retry_nz ? 4'd3 : 4'd0;
         load_code(VECS[v].code);
         push_words(int'(VECS[v].words), VECS[v].eop);
         check(req_tag(int'(VECS[v].req)), $sformatf("vector %0d release", v),
               release_o, VECS[v].exp);
      end
      retry_limit_i = 4'd3;

      // R4 and R5: store-and-forward indication
      do_reset();
      load_code(2'b00);
      @(negedge clk);
      check("R4", "sf_mode with code 00", sf_mode_o, 1);
      do_reset();
      retry_limit_i = 4'd0;
      @(negedge clk);
      check("R5", "sf_mode with zero retries", sf_mode_o, 1);
      retry_limit_i = 4'd3;

      // R10: single release of an open packet
      do_reset();
      load_code(2'b11);
      push_words(128, 1'b0);
      check("R10", "open packet released at 512 B", release_o, 1);
      strobe_start();
      check("R10", "no release right after start", release_o, 0);
      push_words(10, 1'b0);
      check("R10", "no second release while writing", release_o, 0);

      // R6: underrun while the open packet is on the link
      @(negedge clk); fifo_empty_i = 1'b1;
      @(negedge clk); fifo_empty_i = 1'b0;
      check("R6", "underrun strobe", underrun_o, 1);
      check("R6", "pkt_err raised", pkt_err_o, 1);
      @(negedge clk);
      check("R6", "underrun strobe one cycle", underrun_o, 0);
      check("R6", "pkt_err held", pkt_err_o, 1);

      // R7: retry waits for the complete packet
      check("R7", "sf_mode forced", sf_mode_o, 1);
      push_words(200, 1'b0);
      check("R7", "no cut-through on retry", release_o, 0);
      push_words(1, 1'b1);
      check("R7", "retry released when complete", release_o, 1);
      strobe_start();
      @(negedge clk); err_ack_i = 1'b1;
      @(negedge clk); err_ack_i = 1'b0;
      check("R6", "pkt_err cleared by ack", pkt_err_o, 0);

      // R8: override clears after the retry attempt
      check("R8", "sf_mode before retry done", sf_mode_o, 1);
      strobe_done();
      check("R8", "sf_mode after retry done", sf_mode_o, 0);
      push_words(128, 1'b0);
      check("R8", "cut-through restored", release_o, 1);

      // R9: pipeline limit
      do_reset();
      load_code(2'b11);
      no_pipe_i = 1'b1;
      push_words(3, 1'b1);
      check("R9", "first packet released", release_o, 1);
      strobe_start();
      push_words(3, 1'b1);
      check("R9", "held with pipelining off", release_o, 0);
      no_pipe_i = 1'b0;
      @(negedge clk);
      check("R9", "released with pipelining on", release_o, 1);
      strobe_start();
      push_words(3, 1'b1);
      check("R9", "held at pipeline depth", release_o, 0);
      strobe_done();
      check("R9", "released after one done", release_o, 1);

      close_run();
   end

endmodule